// File: doc/BRIEF.md
# Burst ROM Read Controller

This block drives external read cycles for a single ROM address area on behalf of a CPU-side requester. A requester raises a read request with an address. The controller asserts chip select and read strobe for the length of one bus cycle, samples the ROM data on the final state of that cycle, and hands the word back with a single-cycle ready pulse.

A small control register selects between plain operation and burst operation. In plain operation every read takes a full initial cycle. In burst operation, a read that falls in the same aligned block as the previous completed read is served by a shorter burst cycle. The burst cycle lasts two or three states, as set in the register. The block size is set by a second register bit, which chooses how many upper address bits must match. Leaving the area, switching burst operation off, or any non-read request cancels the burst chain, so the next read is a full cycle again.

Top module: `romBurstCtrl`

## Requirements
- R1: After reset the control register reads 0x0A: burst off (bit 0 = 0), three-state burst timing (bit 1 = 1), short block (bit 2 = 0), and the reserved bit 3 = 1. Also after reset, extCsN and extRdN are high and reqReady is low.
- R2: A register write stores bits 0 to 2. Read-back bit 3 is always 1 whatever was written, and read-back bits 7 to 4 are always 0.
- R3: With bit 0 clear (plain operation), every read holds extCsN and extRdN low for exactly 3 clock cycles, whatever the address sequence.
- R4: With bit 0 set, the first read after burst operation is enabled takes the full 3-cycle length.
- R5: With bit 0 set and bit 2 clear, a read whose reqAddr[ADDR_W-1:4] equals that of the previous completed read is a burst cycle. A burst cycle is 2 cycles long when bit 1 is clear and 3 cycles long when bit 1 is set. A read whose upper bits differ takes 3 cycles.
- R6: With bit 0 and bit 2 set, the burst match compares reqAddr[ADDR_W-1:5] instead, so reads up to 32 addresses apart may burst.
- R7: The burst chain is cancelled by any cycle with areaSel low, by clearing bit 0, or by a request with reqRead low. The next read then takes 3 cycles.
- R8: During a cycle, extAddr equals the requested address. rdData takes the value of extData on the last strobe cycle. reqReady is high for exactly one cycle, in the cycle after the strobes rise. rdData holds until the next read completes.
- R9: A request with reqRead low, or with areaSel low, starts no external cycle and produces no reqReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 8 | Control register write value |
| cfgRdData | output | 8 | Control register read-back |
| reqValid | input | 1 | Request present; held until reqReady |
| reqRead | input | 1 | 1 = read request, 0 = other bus activity |
| areaSel | input | 1 | Address falls in this controller's area |
| reqAddr | input | ADDR_W | Request address |
| reqReady | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Returned read data |
| extAddr | output | ADDR_W | External address |
| extCsN | output | 1 | External chip select, active low |
| extRdN | output | 1 | External read strobe, active low |
| extData | input | DATA_W | External ROM data |

## Verification
The bench sweeps all eight register settings over address walks that cross 16- and 32-address block edges, repeat addresses and jump far away. It predicts each cycle length from a small arithmetic model. A design that compared the wrong address bits would use burst cycles across a block edge, or miss bursts inside a block. A design that ignored the timing bit would show 2 or 3 strobe cycles in the wrong places. The bench drives a different data word on each strobe state, so capture on an earlier state is caught. Non-read requests, areaSel drops and register toggles are inserted into the walks. A design that kept the burst chain through any of them would show a 2-cycle read where 3 are expected.

// File: rtl/romBurstPkg.sv
package romBurstPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_DONE   = 2'd2
  } busStateT;

  typedef struct packed {
    logic load;     // latch request address at cycle start
    logic capture;  // sample external data on final state
    logic commit;   // record completed address for burst match
  } dpStrobeT;

  typedef struct packed {
    logic burstEn;
    logic slowBurst;
    logic longBlock;
  } cfgT;

endpackage

// File: rtl/romBurstCfg.sv
module romBurstCfg
  import romBurstPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  output logic [7:0] cfgRdData,
  output cfgT        cfg
);

  cfgT cfgQ;
  logic unusedWrBits;

  assign unusedWrBits = ^cfgWrData[7:3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ.burstEn   <= 1'b0;
      cfgQ.slowBurst <= 1'b1;
      cfgQ.longBlock <= 1'b0;
    end else if (cfgWrEn) begin
      cfgQ.burstEn   <= cfgWrData[0];
      cfgQ.slowBurst <= cfgWrData[1];
      cfgQ.longBlock <= cfgWrData[2];
    end
  end

  assign cfg       = cfgQ;
  assign cfgRdData = {4'b0000, 1'b1, cfgQ.longBlock, cfgQ.slowBurst, cfgQ.burstEn};

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(cfgRdData)); // R2

endmodule

// File: rtl/romBurstCtl.sv
module romBurstCtl
  import romBurstPkg::*;
#(
  parameter int FULL_STATES = 3,
  parameter int FAST_STATES = 2,
  parameter int SLOW_STATES = 3,
  localparam int MAX_STATES = (FULL_STATES > SLOW_STATES) ?
                              ((FULL_STATES > FAST_STATES) ? FULL_STATES : FAST_STATES) :
                              ((SLOW_STATES > FAST_STATES) ? SLOW_STATES : FAST_STATES),
  localparam int CNT_W = (MAX_STATES > 1) ? $clog2(MAX_STATES) : 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  cfgT      cfg,
  input  logic     reqValid,
  input  logic     reqRead,
  input  logic     areaSel,
  input  logic     addrMatch,
  output dpStrobeT strb,
  output logic     reqReady,
  output logic     extCsN,
  output logic     extRdN
);

  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(FULL_STATES - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_STATES - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_STATES - 1);

  busStateT         stateQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] lastQ;
  logic             chainQ;
  logic             startReq;
  logic             burstHit;
  logic             lastState;
  logic             chainKill;
  logic [CNT_W-1:0] lastNext;

  assign startReq  = (stateQ == ST_IDLE) && reqValid && areaSel && reqRead;
  assign burstHit  = chainQ && cfg.burstEn && addrMatch;
  assign lastState = (stateQ == ST_ACCESS) && (cntQ == lastQ);
  assign chainKill = !areaSel || !cfg.burstEn || (reqValid && !reqRead);

  always_comb begin
    if (burstHit) begin
      lastNext = cfg.slowBurst ? SLOW_LAST : FAST_LAST;
    end else begin
      lastNext = FULL_LAST;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      lastQ  <= FULL_LAST;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (startReq) begin
            stateQ <= ST_ACCESS;
            cntQ   <= '0;
            lastQ  <= lastNext;
          end
        end
        ST_ACCESS: begin
          if (cntQ == lastQ) begin
            stateQ <= ST_DONE;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        ST_DONE: begin
          stateQ <= ST_IDLE;
        end
        default: begin
          stateQ <= ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainQ <= 1'b0;
    end else if (chainKill) begin
      chainQ <= 1'b0;
    end else if (lastState) begin
      chainQ <= 1'b1;
    end
  end

  assign strb.load    = startReq;
  assign strb.capture = lastState;
  assign strb.commit  = lastState;

  assign reqReady = (stateQ == ST_DONE);
  assign extCsN   = (stateQ != ST_ACCESS);
  assign extRdN   = (stateQ != ST_ACCESS);

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady); // R8
  AST_CHAIN_AREA_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !areaSel |=> !chainQ); // R7
  AST_PLAIN_FULL_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !cfg.burstEn) |=> (lastQ == FULL_LAST)); // R3
  AST_NONREAD_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_IDLE) && !(reqValid && reqRead && areaSel)) |=> extCsN); // R9

endmodule

// File: rtl/romBurstDp.sv
module romBurstDp
  import romBurstPkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int SHORT_LSB = 4,
  localparam int LONG_LSB = SHORT_LSB + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strb,
  input  logic              longBlock,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] extData,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              addrMatch
);

  localparam logic [ADDR_W-1:0] SHORT_MASK = ~((ADDR_W'(1) << SHORT_LSB) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] LONG_MASK  = ~((ADDR_W'(1) << LONG_LSB) - ADDR_W'(1));

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] prevQ;
  logic [DATA_W-1:0] dataQ;
  logic [ADDR_W-1:0] matchMask;

  assign matchMask = longBlock ? LONG_MASK : SHORT_MASK;
  assign addrMatch = ((reqAddr ^ prevQ) & matchMask) == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      prevQ <= '0;
      dataQ <= '0;
    end else begin
      if (strb.load) begin
        addrQ <= reqAddr;
      end
      if (strb.commit) begin
        prevQ <= addrQ;
      end
      if (strb.capture) begin
        dataQ <= extData;
      end
    end
  end

  assign extAddr = addrQ;
  assign rdData  = dataQ;

  AST_PREV_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(prevQ)); // R5
  AST_DATA_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(rdData)); // R8

endmodule

// File: rtl/romBurstCtrl.sv
module romBurstCtrl
  import romBurstPkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter int SHORT_LSB   = 4,
  parameter int FULL_STATES = 3,
  parameter int FAST_STATES = 2,
  parameter int SLOW_STATES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              reqValid,
  input  logic              reqRead,
  input  logic              areaSel,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] extAddr,
  output logic              extCsN,
  output logic              extRdN,
  input  logic [DATA_W-1:0] extData
);

  cfgT      cfg;
  dpStrobeT strb;
  logic     addrMatch;

  romBurstCfg u_cfg (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .cfg       (cfg)
  );

  romBurstCtl #(
    .FULL_STATES (FULL_STATES),
    .FAST_STATES (FAST_STATES),
    .SLOW_STATES (SLOW_STATES)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .cfg       (cfg),
    .reqValid  (reqValid),
    .reqRead   (reqRead),
    .areaSel   (areaSel),
    .addrMatch (addrMatch),
    .strb      (strb),
    .reqReady  (reqReady),
    .extCsN    (extCsN),
    .extRdN    (extRdN)
  );

  romBurstDp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SHORT_LSB (SHORT_LSB)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .longBlock (cfg.longBlock),
    .reqAddr   (reqAddr),
    .extData   (extData),
    .extAddr   (extAddr),
    .rdData    (rdData),
    .addrMatch (addrMatch)
  );

  AST_ADDR_HELD_IN_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (!extRdN && $past(!extRdN)) |-> $stable(extAddr)); // R8

endmodule

// File: tb/romBurstCtrl_tb_top.sv
module romBurstCtrl_tb_top;

  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [7:0]    cfgWrData = '0;
  logic [7:0]    cfgRdData;
  logic          reqValid = 1'b0;
  logic          reqRead = 1'b1;
  logic          areaSel = 1'b1;
  logic [AW-1:0] reqAddr = '0;
  logic          reqReady;
  logic [DW-1:0] rdData;
  logic [AW-1:0] extAddr;
  logic          extCsN;
  logic          extRdN;
  logic [DW-1:0] extData = '0;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  logic          mValid;
  logic [AW-1:0] mPrev;
  logic [2:0]    mCfg;

  romBurstCtrl dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .reqValid(reqValid), .reqRead(reqRead),
    .areaSel(areaSel), .reqAddr(reqAddr), .reqReady(reqReady), .rdData(rdData),
    .extAddr(extAddr), .extCsN(extCsN), .extRdN(extRdN), .extData(extData)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(input logic [AW-1:0] a, input int st);
    return {a, 4'(st)};
  endfunction

  task automatic cfgWrite(input logic [7:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
    mCfg = v[2:0];
    if (!v[0]) mValid = 1'b0;
  endtask

  function automatic int predictLen(input logic [AW-1:0] a);
    int lsb;
    lsb = mCfg[2] ? 5 : 4;
    if (mCfg[0] && mValid && ((a >> lsb) == (mPrev >> lsb)))
      return mCfg[1] ? 3 : 2;
    return 3;
  endfunction

  task automatic doRead(input logic [AW-1:0] a, input string req);
    int expLen, lowCnt;
    bit got, addrOk;
    logic [DW-1:0] held;
    expLen = predictLen(a);
    lowCnt = 0; got = 0; addrOk = 1;
    @(negedge clk);
    reqValid = 1'b1; reqRead = 1'b1; areaSel = 1'b1; reqAddr = a;
    for (int t = 0; t < 20 && !got; t++) begin
      @(negedge clk);
      if (!extRdN) begin
        lowCnt++;
        if (extAddr !== a || extCsN !== 1'b0) addrOk = 0;
        extData = mk(a, lowCnt);
      end
      if (reqReady) got = 1;
    end
    reqValid = 1'b0;
    check(got, "R8 ready seen", int'(got), 1);
    check(lowCnt == expLen, req, lowCnt, expLen);
    check(addrOk, "R8 address and select during cycle", int'(addrOk), 1);
    check(rdData === mk(a, expLen), "R8 data from last state", int'(rdData), int'(mk(a, expLen)));
    held = rdData;
    @(negedge clk);
    check(reqReady === 1'b0, "R8 ready single pulse", int'(reqReady), 0);
    check(rdData === held, "R8 data held", int'(rdData), int'(held));
    mPrev = a;
    if (mCfg[0]) mValid = 1'b1;
  endtask

  task automatic quietReq(input bit rd, input bit sel, input string req);
    bit quiet;
    quiet = 1;
    @(negedge clk);
    reqValid = 1'b1; reqRead = rd; areaSel = sel; reqAddr = 12'h5a5;
    @(negedge clk);
    reqValid = 1'b0; reqRead = 1'b1; areaSel = 1'b1;
    if (extCsN !== 1'b1 || extRdN !== 1'b1 || reqReady !== 1'b0) quiet = 0;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      if (extCsN !== 1'b1 || extRdN !== 1'b1 || reqReady !== 1'b0) quiet = 0;
    end
    check(quiet, req, int'(quiet), 1);
    mValid = 1'b0;
  endtask

  initial begin
    mValid = 1'b0; mPrev = '0; mCfg = 3'b010;
    repeat (3) @(negedge clk);
    check(cfgRdData === 8'h0A, "R1 register reset value", int'(cfgRdData), 8'h0A);
    check(extCsN === 1'b1 && extRdN === 1'b1, "R1 strobes idle in reset", int'({extCsN, extRdN}), 3);
    check(reqReady === 1'b0, "R1 ready low in reset", int'(reqReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(cfgRdData === 8'h0A, "R1 register after reset release", int'(cfgRdData), 8'h0A);

    for (int v = 0; v < 256; v++) begin
      cfgWrite(8'(v));
      check(cfgRdData === {4'b0000, 1'b1, 3'(v)}, "R2 register read-back",
            int'(cfgRdData), int'({4'b0000, 1'b1, 3'(v)}));
    end

    for (int c = 0; c < 8; c++) begin
      cfgWrite(8'h00);
      cfgWrite(8'(c));
      for (int i = 0; i < 24; i++) begin
        logic [AW-1:0] a;
        a = AW'((i * 5) & 63) ^ ((i % 7 == 3) ? 12'h200 : 12'h000);
        if (i % 6 == 0) a = mPrev;
        if (i == 0) doRead(a, "R4 first read after enable is full");
        else if (c[0] == 1'b0) doRead(a, "R3 plain mode full cycle");
        else if (c[2]) doRead(a, "R6 long block burst length");
        else doRead(a, "R5 short block burst length");
        if (i % 8 == 5) quietReq(1'b0, 1'b1, "R9 non-read request starts no cycle");
        if (i % 8 == 2) quietReq(1'b1, 1'b0, "R9 unselected request starts no cycle");
      end
    end

    cfgWrite(8'h01);
    doRead(12'h100, "R4 first read after enable");
    doRead(12'h102, "R5 burst inside block");
    doRead(12'h10f, "R5 burst at block top");
    doRead(12'h110, "R5 block edge crossing is full");
    cfgWrite(8'h00);
    cfgWrite(8'h01);
    doRead(12'h112, "R7 disable cancels burst");
    doRead(12'h114, "R5 burst resumes");
    quietReq(1'b0, 1'b1, "R9 non-read request");
    doRead(12'h116, "R7 non-read cancels burst");
    @(negedge clk); areaSel = 1'b0;
    @(negedge clk); areaSel = 1'b1;
    mValid = 1'b0;
    doRead(12'h118, "R7 area deselect cancels burst");
    cfgWrite(8'h05);
    mValid = 1'b0;
    doRead(12'h120, "R6 first read long block");
    doRead(12'h13f, "R6 burst across 16 boundary");
    doRead(12'h140, "R6 32 boundary crossing is full");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule